// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration register front end of a multi-function I/O controller. Software reaches it through two byte-wide ports sharing one bus: an index port and a data port, chosen by a single port-select bit. Configuration access starts closed. It opens only when an unlock key byte is written to the index port twice in a row. A separate lock key written to the index port closes it again. While access is closed, every read returns 0xFF, so software can probe for the controller by reading the port.

While access is open, a byte written to the index port selects a configuration register. The data port then reads or writes that register. A global select register picks one of several logical devices. The enable, base-address and interrupt registers are banked per device, so the data port reaches only the bank of the selected device. Two read-only chip identification bytes are also readable. The block drives each device's enable bit, its 16-bit I/O base address and its IRQ number as outputs, for the device decoders that sit beside it.

Register indices: device select 0x0F, chip ID major 0x1E, chip ID minor 0x1F, device enable 0x40, base high byte 0x44, base low byte 0x45, IRQ 0x48. The default unlock key is 0x5A and the default lock key is 0xA5. The default chip ID is 0xC5 (major) and 0x31 (minor). There are 8 logical devices by default, and IRQ fields are 4 bits wide.

Top module: `cfgp_top`

## Requirements
- R1: After reset, access is closed, `bus_rdata` is 0xFF, and every device has enable 0, base address 0 and IRQ 0. The selected device and the index both reset to 0.
- R2: Access opens (`cfg_open` = 1) only after two consecutive index-port writes of the unlock key. After a single unlock-key write, access stays closed and reads still return 0xFF.
- R3: An index-port write of any value other than the unlock key, made before the second unlock-key write, restarts the sequence. Two further unlock-key writes are then needed.
- R4: While access is open, an index-port write of the lock key closes access. Any other value written to the index port is stored as the register index, and reading the index port returns it.
- R5: While access is closed, reads of either port return 0xFF, and data-port writes change no register and no output.
- R6: A data write to index 0x0F stores the low log2(number of devices) bits as the selected device. Reads and writes of indices 0x40, 0x44, 0x45 and 0x48 reach only that device's bank.
- R7: A data write to index 0x40 sets the selected device's enable to bit 0 of the byte: 1 activates the device and 0 deactivates it. The enable reads back as 0x00 or 0x01 and drives that device's bit of `dev_active`.
- R8: Indices 0x44 and 0x45 hold the high and low bytes of the selected device's 16-bit base address. Both read back, and together they drive that device's slice of `dev_base`.
- R9: Index 0x48 holds the low 4 bits of the written byte as the selected device's IRQ. It reads back zero-extended and drives that device's slice of `dev_irq`.
- R10: Indices 0x1E and 0x1F read the chip ID major byte (0xC5) and minor byte (0x31). Data writes to them have no effect.
- R11: A read is registered. The clock edge that samples `bus_rd` loads `bus_rdata`, and the value holds until the next read or reset. Reads of unmapped indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_port | input | 1 | Port select: 0 index port, 1 data port |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Configuration access is open |
| dev_active | output | NUM_DEV | Per-device enable |
| dev_base | output | NUM_DEV*16 | Per-device base address, device i in bits 16i+15..16i |
| dev_irq | output | NUM_DEV*IRQ_W | Per-device IRQ number, device i in bits IRQ_W*i+IRQ_W-1..IRQ_W*i |

## Verification
A write updates the key state, the index and the device bank at the rising edge that samples it. `cfg_open`, `dev_active`, `dev_base` and `dev_irq` therefore show the new value right after that edge. A read loads `bus_rdata` at the edge that samples `bus_rd`, so the result is due one edge after the strobe is applied. The bench drives every strobe on a falling edge for exactly one cycle. It samples both the read data and the port outputs on the following falling edge, half a cycle after the only register stage in the path.

// File: rtl/cfgp_pkg.sv
// Package: shared constants and types for the keyed configuration port.
// Assumes: byte-wide bus and register indices fixed at the values below.
package cfgp_pkg;
    typedef enum logic [1:0] {
        KL_LOCKED = 2'd0,
        KL_HALF   = 2'd1,
        KL_OPEN   = 2'd2
    } kl_state_e;

    localparam logic [7:0] IDX_DEVSEL  = 8'h0F;
    localparam logic [7:0] IDX_CHIP_HI = 8'h1E;
    localparam logic [7:0] IDX_CHIP_LO = 8'h1F;
    localparam logic [7:0] IDX_EN      = 8'h40;
    localparam logic [7:0] IDX_BASE_HI = 8'h44;
    localparam logic [7:0] IDX_BASE_LO = 8'h45;
    localparam logic [7:0] IDX_IRQ     = 8'h48;

    localparam logic [7:0] DEF_UNLOCK  = 8'h5A;
    localparam logic [7:0] DEF_LOCK    = 8'hA5;
    localparam logic [7:0] LOCKED_READ = 8'hFF;
endpackage

// File: rtl/cfgp_keylock.sv
// Module: cfgp_keylock
// Tracks the key sequence on index-port writes. Access opens after two
// consecutive unlock-key writes and closes on the lock key. While access is
// open, it raises idx_load for every other index byte.
// Assumes: idx_wr is a single-cycle strobe for index-port writes only.
module cfgp_keylock
    import cfgp_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = DEF_UNLOCK,
    parameter logic [7:0] LOCK_KEY   = DEF_LOCK
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       is_open,
    output logic       idx_load
);
    kl_state_e state;

    // Purpose: advance the unlock sequence and handle the lock key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KL_LOCKED;
        end else if (idx_wr) begin
            case (state)
                KL_LOCKED: state <= (wdata == UNLOCK_KEY) ? KL_HALF : KL_LOCKED;
                KL_HALF:   state <= (wdata == UNLOCK_KEY) ? KL_OPEN : KL_LOCKED;
                KL_OPEN:   state <= (wdata == LOCK_KEY)   ? KL_LOCKED : KL_OPEN;
                default:   state <= KL_LOCKED;
            endcase
        end
    end

    // Purpose: decode the open flag and the index-register load strobe.
    always_comb begin
        is_open  = (state == KL_OPEN);
        idx_load = idx_wr && is_open && (wdata != LOCK_KEY);
    end
endmodule

// File: rtl/cfgp_bank.sv
// Module: cfgp_bank
// Holds one logical device's enable, 16-bit base address and IRQ field.
// Assumes: the parent has already qualified each write enable with the
// open state, the register index and the device select.
module cfgp_bank #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_en,
    input  logic             we_base_hi,
    input  logic             we_base_lo,
    input  logic             we_irq,
    input  logic [7:0]       wdata,
    output logic             active,
    output logic [15:0]      base,
    output logic [IRQ_W-1:0] irq
);
    // Purpose: store the banked registers, all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= 16'h0000;
            irq    <= '0;
        end else begin
            if (we_en)      active     <= wdata[0];
            if (we_base_hi) base[15:8] <= wdata;
            if (we_base_lo) base[7:0]  <= wdata;
            if (we_irq)     irq        <= wdata[IRQ_W-1:0];
        end
    end
endmodule

// File: rtl/cfgp_top.sv
// Module: cfgp_top
// Configuration front end reached through an index port and a data port.
// It contains a key lock, an index register, a logical-device select,
// per-device banks, read-only chip ID bytes and a registered read path.
// Assumes: bus_wr and bus_rd are never asserted in the same cycle, and
// IRQ_W is at most 8.
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int         NUM_DEV    = 8,
    parameter int         IRQ_W      = 4,
    parameter logic [7:0] UNLOCK_KEY = DEF_UNLOCK,
    parameter logic [7:0] LOCK_KEY   = DEF_LOCK,
    parameter logic [7:0] CHIP_MAJOR = 8'hC5,
    parameter logic [7:0] CHIP_MINOR = 8'h31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic                     bus_port,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic                     cfg_open,
    output logic [NUM_DEV-1:0]       dev_active,
    output logic [NUM_DEV*16-1:0]    dev_base,
    output logic [NUM_DEV*IRQ_W-1:0] dev_irq
);
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             idx_wr;
    logic             idx_load;
    logic             data_wr;
    logic [7:0]       index_q;
    logic [DEV_W-1:0] dev_sel;
    logic [7:0]       data_mux;
    logic             act_arr  [NUM_DEV];
    logic [15:0]      base_arr [NUM_DEV];
    logic [IRQ_W-1:0] irq_arr  [NUM_DEV];

    // Purpose: split the bus strobes into index-port and data-port writes.
    always_comb begin
        idx_wr  = bus_wr && !bus_port;
        data_wr = bus_wr && bus_port && cfg_open;
    end

    cfgp_keylock #(
        .UNLOCK_KEY (UNLOCK_KEY),
        .LOCK_KEY   (LOCK_KEY)
    ) u_keylock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .is_open  (cfg_open),
        .idx_load (idx_load)
    );

    // Purpose: hold the register index selected through the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= 8'h00;
        else if (idx_load) index_q <= bus_wdata;
    end

    // Purpose: hold the global logical-device select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_sel <= '0;
        else if (data_wr && index_q == IDX_DEVSEL)
            dev_sel <= bus_wdata[DEV_W-1:0];
    end

    for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_bank
        logic hit;
        assign hit = data_wr && (dev_sel == DEV_W'(gi));

        cfgp_bank #(.IRQ_W(IRQ_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_en      (hit && index_q == IDX_EN),
            .we_base_hi (hit && index_q == IDX_BASE_HI),
            .we_base_lo (hit && index_q == IDX_BASE_LO),
            .we_irq     (hit && index_q == IDX_IRQ),
            .wdata      (bus_wdata),
            .active     (act_arr[gi]),
            .base       (base_arr[gi]),
            .irq        (irq_arr[gi])
        );

        assign dev_active[gi]               = act_arr[gi];
        assign dev_base[gi*16 +: 16]        = base_arr[gi];
        assign dev_irq[gi*IRQ_W +: IRQ_W]   = irq_arr[gi];
    end

    // Purpose: select the data-port read value for the current index.
    always_comb begin
        case (index_q)
            IDX_DEVSEL:  data_mux = 8'(dev_sel);
            IDX_CHIP_HI: data_mux = CHIP_MAJOR;
            IDX_CHIP_LO: data_mux = CHIP_MINOR;
            IDX_EN:      data_mux = {7'b0, act_arr[dev_sel]};
            IDX_BASE_HI: data_mux = base_arr[dev_sel][15:8];
            IDX_BASE_LO: data_mux = base_arr[dev_sel][7:0];
            IDX_IRQ:     data_mux = 8'(irq_arr[dev_sel]);
            default:     data_mux = 8'h00;
        endcase
    end

    // Purpose: register read data, forced to 0xFF while access is closed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= LOCKED_READ;
        else if (bus_rd)
            bus_rdata <= !cfg_open ? LOCKED_READ : (bus_port ? data_mux : index_q);
    end
endmodule

// File: rtl/cfgp_chk.sv
// Module: cfgp_chk
// Checker bound to cfgp_top. It observes only the ports of the top module.
// Assumes: the same key parameters as the top module it is bound to.
module cfgp_chk #(
    parameter int         NUM_DEV    = 8,
    parameter int         IRQ_W      = 4,
    parameter logic [7:0] UNLOCK_KEY = 8'h5A,
    parameter logic [7:0] LOCK_KEY   = 8'hA5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic                     bus_port,
    input logic [7:0]               bus_wdata,
    input logic [7:0]               bus_rdata,
    input logic                     cfg_open,
    input logic [NUM_DEV-1:0]       dev_active,
    input logic [NUM_DEV*16-1:0]    dev_base,
    input logic [NUM_DEV*IRQ_W-1:0] dev_irq
);
    // R2: access opens only right after an unlock-key index write.
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && !bus_port && bus_wdata == UNLOCK_KEY));

    // R4: the lock key closes access.
    a_r4_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && !bus_port && bus_wdata == LOCK_KEY) |=> !cfg_open);

    // R5: reads while closed return 0xFF.
    a_r5_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_open) |=> (bus_rdata == 8'hFF));

    // R5: data writes while closed leave every device output unchanged.
    a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port && !cfg_open) |=>
            ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq)));

    // R7: an enable changes only after an open data-port write.
    a_r7_active_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_active) |-> $past(cfg_open && bus_wr && bus_port));

    // R11: read data changes only after a read strobe.
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_rdata) |-> $past(bus_rd));
endmodule

bind cfgp_top cfgp_chk #(
    .NUM_DEV    (NUM_DEV),
    .IRQ_W      (IRQ_W),
    .UNLOCK_KEY (UNLOCK_KEY),
    .LOCK_KEY   (LOCK_KEY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_port   (bus_port),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_open   (cfg_open),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_irq    (dev_irq)
);

// File: tb/cfgp_top_tb.sv
`timescale 1ns/1ps
module cfgp_top_tb;
    localparam int NUM_DEV = 8;
    localparam int IRQ_W   = 4;

    localparam logic [1:0] OP_WI = 2'd0; // write index port
    localparam logic [1:0] OP_WD = 2'd1; // write data port
    localparam logic [1:0] OP_RD = 2'd2; // read data port, compare
    localparam logic [1:0] OP_RI = 2'd3; // read index port, compare

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] val;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, 8'h00, 8'hFF, 8'd5},  // R5 locked read
        '{OP_WI, 8'h5A, 8'h00, 8'd2},
        '{OP_RD, 8'h00, 8'hFF, 8'd2},  // R2 one key is not enough
        '{OP_WI, 8'h5A, 8'h00, 8'd2},
        '{OP_WI, 8'h1E, 8'h00, 8'd10},
        '{OP_RD, 8'h00, 8'hC5, 8'd10}, // R10 major
        '{OP_WI, 8'h1F, 8'h00, 8'd10},
        '{OP_RD, 8'h00, 8'h31, 8'd10}, // R10 minor
        '{OP_WD, 8'h00, 8'h00, 8'd10},
        '{OP_RD, 8'h00, 8'h31, 8'd10}, // R10 write ignored
        '{OP_WI, 8'h0F, 8'h00, 8'd6},
        '{OP_WD, 8'hFA, 8'h00, 8'd6},
        '{OP_RD, 8'h00, 8'h02, 8'd6},  // R6 select truncated to 3 bits
        '{OP_WI, 8'h40, 8'h00, 8'd7},
        '{OP_WD, 8'h01, 8'h00, 8'd7},
        '{OP_RD, 8'h00, 8'h01, 8'd7},  // R7 enable readback
        '{OP_WI, 8'h44, 8'h00, 8'd8},
        '{OP_WD, 8'h12, 8'h00, 8'd8},
        '{OP_WI, 8'h45, 8'h00, 8'd8},
        '{OP_WD, 8'h34, 8'h00, 8'd8},
        '{OP_RD, 8'h00, 8'h34, 8'd8},  // R8 low byte
        '{OP_WI, 8'h48, 8'h00, 8'd9},
        '{OP_WD, 8'hFB, 8'h00, 8'd9},
        '{OP_RD, 8'h00, 8'h0B, 8'd9},  // R9 irq low bits
        '{OP_WI, 8'h0F, 8'h00, 8'd6},
        '{OP_WD, 8'h03, 8'h00, 8'd6},
        '{OP_WI, 8'h44, 8'h00, 8'd6},
        '{OP_RD, 8'h00, 8'h00, 8'd6},  // R6 other bank untouched
        '{OP_WI, 8'h0F, 8'h00, 8'd6},
        '{OP_WD, 8'h02, 8'h00, 8'd6},
        '{OP_WI, 8'h44, 8'h00, 8'd8},
        '{OP_RD, 8'h00, 8'h12, 8'd8},  // R8 high byte
        '{OP_RI, 8'h00, 8'h44, 8'd4},  // R4 index readback
        '{OP_WI, 8'h77, 8'h00, 8'd11},
        '{OP_RD, 8'h00, 8'h00, 8'd11}, // R11 unmapped reads 0
        '{OP_WI, 8'h40, 8'h00, 8'd4},
        '{OP_WI, 8'hA5, 8'h00, 8'd4},
        '{OP_RD, 8'h00, 8'hFF, 8'd4},  // R4 locked again
        '{OP_RI, 8'h00, 8'hFF, 8'd5},  // R5 index read locked
        '{OP_WD, 8'h00, 8'h00, 8'd5},  // R5 must be ignored
        '{OP_RD, 8'h00, 8'hFF, 8'd5},
        '{OP_RI, 8'h00, 8'hFF, 8'd5}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     bus_wr = 1'b0;
    logic                     bus_rd = 1'b0;
    logic                     bus_port = 1'b0;
    logic [7:0]               bus_wdata = 8'h00;
    logic [7:0]               bus_rdata;
    logic                     cfg_open;
    logic [NUM_DEV-1:0]       dev_active;
    logic [NUM_DEV*16-1:0]    dev_base;
    logic [NUM_DEV*IRQ_W-1:0] dev_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cfgp_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_port   (bus_port),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg_open   (cfg_open),
        .dev_active (dev_active),
        .dev_base   (dev_base),
        .dev_irq    (dev_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One bus operation: strobe for one cycle from a falling edge, then
    // sample on the next falling edge.
    task automatic bus_op(input logic [1:0] op, input logic [7:0] val, output logic [7:0] rd);
        @(negedge clk);
        bus_port  = (op == OP_WD) || (op == OP_RD);
        bus_wr    = (op == OP_WI) || (op == OP_WD);
        bus_rd    = (op == OP_RD) || (op == OP_RI);
        bus_wdata = val;
        @(negedge clk);
        rd        = bus_rdata;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
    endtask

    task automatic wr(input logic [1:0] op, input logic [7:0] val);
        logic [7:0] dummy;
        bus_op(op, val, dummy);
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(32'(cfg_open), 32'd0, "R1 cfg_open");
        check(32'(bus_rdata), 32'hFF, "R1 rdata");
        check(32'(dev_active), 32'd0, "R1 active");
        check(32'(dev_base[31:0]), 32'd0, "R1 base");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].op, VECS[i].val, rd);
            if (VECS[i].op == OP_RD || VECS[i].op == OP_RI)
                check(32'(rd), 32'(VECS[i].exp), $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R5: the locked write to index 0x40 left device 2 active
        check(32'(dev_active), 32'h04, "R5 locked write ignored");
        check(32'(dev_base[47:32]), 32'h1234, "R8 device 2 base");
        check(32'(dev_base[63:48]), 32'h0000, "R6 device 3 base");
        check(32'(dev_irq[11:8]), 32'hB, "R9 device 2 irq");
        check(32'(cfg_open), 32'd0, "R4 closed");

        // R3: an interrupting index write restarts the sequence
        wr(OP_WI, 8'h5A);
        wr(OP_WI, 8'h11);
        wr(OP_WI, 8'h5A);
        check(32'(cfg_open), 32'd0, "R3 interrupted sequence");
        wr(OP_WI, 8'h5A);
        check(32'(cfg_open), 32'd1, "R2 consecutive keys open");

        // R7: writing 0 deactivates the selected device
        wr(OP_WI, 8'h0F);
        wr(OP_WD, 8'h02);
        wr(OP_WI, 8'h40);
        wr(OP_WD, 8'h00);
        check(32'(dev_active), 32'h00, "R7 deactivate");

        // R11: read data holds until the next read
        bus_op(OP_RI, 8'h00, rd);
        check(32'(rd), 32'h40, "R11 index read");
        wr(OP_WI, 8'h1E);
        check(32'(bus_rdata), 32'h40, "R11 rdata holds");

        // R1: a second reset clears banks and closes access
        wr(OP_WI, 8'h44);
        wr(OP_WD, 8'h9C);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(32'(cfg_open), 32'd0, "R1 reset closes");
        check(32'(dev_base[47:32]), 32'h0000, "R1 reset clears base");
        check(32'(bus_rdata), 32'hFF, "R1 reset rdata");
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule